// File: doc/BRIEF.md
# Byte-Lane Controller for a 64K x 16 Asynchronous Static RAM

This block turns a simple one-request-at-a-time user interface into the strobe sequences for an external asynchronous static RAM. The RAM holds 65536 words of 16 bits. Two active-low lane enables select the high and low byte independently. Every interval of the memory's timing is a compile-time count of clock cycles. All strobes leave the block from registers, so the chip sees clean, glitch-free edges.

A read drives chip select, output enable and the lane enables low for the read-cycle count. Write enable stays high for the whole read. The data bus is captured at the end of the address-access count and returned with a one-clock valid strobe. A write uses write enable as the strobe, with output enable held high. Chip select and the lane enables fall first, for an address-setup count. Write enable is then low for the pulse count. The block drives the data bus only from the fall of write enable until the data-hold count after its rise. A write-recovery count with the chip deselected follows. When the direction changes between two accesses, one extra quiet cycle is inserted before the new access.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and right after reset: `req_ready`=1; `sram_cs_n`, `sram_oe_n`, `sram_we_n` are 1; `sram_be_n`=2'b11; `sram_dq_oe`=0; `rsp_valid`=0.
- R2: A read holds `sram_cs_n` and `sram_oe_n` low for exactly T_RC cycles, and `sram_we_n` stays 1 during all of them.
- R3: Read data is sampled at the end of the T_AA-th read cycle and appears on `rsp_rdata`. A lane whose mask bit is 0 reads as zero. Every read produces exactly one response, in request order.
- R4: `rsp_valid` is high for exactly one clock per read.
- R5: `sram_addr` carries the accepted request's address and does not change while `sram_cs_n` stays low.
- R6: A write holds `sram_cs_n` low for T_AS cycles before `sram_we_n` falls. `sram_we_n` is then low for PW cycles, where PW = max(T_WP, T_DW). When OE_LOW_WR=1, PW = max(T_WP, T_WHZ+T_DW). With OE_LOW_WR=0, `sram_oe_n` stays 1 throughout the write.
- R7: `sram_dq_oe` is 1 in every cycle `sram_we_n` is low and in the T_DH cycles after it rises. It is never 1 while `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1.
- R8: Lane mapping: `req_mask[1]` drives `sram_be_n[1]` (data bits 15:8) and `req_mask[0]` drives `sram_be_n[0]` (bits 7:0). Each enable is active low and asserted only while `sram_cs_n` is low. A write with mask 2'b00 keeps both enables at 1 and changes no stored byte.
- R9: `req_ready` is low from acceptance for T_RC cycles after a read, and for T_AS+PW+T_DH+T_WR cycles after a write.
- R10: An access whose direction differs from the previous access keeps `req_ready` low one cycle longer. During that extra cycle all strobes are inactive. The first access after reset adds no such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 1 high byte, bit 0 low byte |
| rsp_valid | output | 1 | Read data valid, one clock |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Lane enables, active low |
| sram_addr | output | 16 | Address bus |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_in | input | 16 | Data returned by the memory |
| sram_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The read-data return and the acceptance of the next request can fall in the same clock. This happens because the address-access count equals the read-cycle count, so `rsp_valid` rises in the idle cycle where `req_ready` is high. The bench provokes this by issuing reads back to back, with the next request already waiting when `req_ready` returns. The scoreboard must receive the earlier read's data in order while the new request is taken. The busy-length check on `req_ready` must still count exactly T_RC cycles for that new read.

// File: rtl/sram_lane_pkg.sv
// Package: shared state encoding, strobe bundle and helpers for the
// static-RAM lane controller. Assumes a single clock domain.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TURN = 3'd1,
        ST_RD   = 3'd2,
        ST_WSET = 3'd3,
        ST_WPUL = 3'd4,
        ST_WHLD = 3'd5,
        ST_WREC = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Larger of two counts.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Memory-side strobe levels that belong to a sequencer state.
    function automatic strobe_t strobes_of(input seq_state_t st, input logic oe_in_write);
        strobe_t s;
        s = STROBE_QUIET;
        case (st)
            ST_RD: begin
                s.cs_n = 1'b0;
                s.oe_n = 1'b0;
            end
            ST_WSET: begin
                s.cs_n = 1'b0;
                s.oe_n = ~oe_in_write;
            end
            ST_WPUL: begin
                s.cs_n  = 1'b0;
                s.oe_n  = ~oe_in_write;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            ST_WHLD: begin
                s.cs_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            default: s = STROBE_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Phase timer: counts clock cycles spent in the current sequencer phase.
// Assumes restart is raised on the edge that enters a new phase; the
// count wraps harmlessly while idle.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);

    // Clear on phase entry, otherwise advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: walks read, write and turnaround phases with lengths
// given by parameters (each at least 1). Assumes fire is only raised in
// ST_IDLE. Issues the read sample strobe at the end of the access count.
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int T_RC  = 3,
    parameter int T_AA  = 3,
    parameter int T_AS  = 1,
    parameter int PW    = 2,
    parameter int T_DH  = 1,
    parameter int T_WR  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             req_wr,
    input  logic [CNT_W-1:0] cnt,
    output seq_state_t       st_q,
    output seq_state_t       st_d,
    output logic             sample
);

    logic             op_wr_q;
    logic             last_wr_q;
    logic             used_q;
    logic [CNT_W-1:0] lim_m1;
    logic             phase_end;

    // Final count value of the current phase.
    always_comb begin
        case (st_q)
            ST_RD:   lim_m1 = CNT_W'(T_RC - 1);
            ST_WSET: lim_m1 = CNT_W'(T_AS - 1);
            ST_WPUL: lim_m1 = CNT_W'(PW - 1);
            ST_WHLD: lim_m1 = CNT_W'(T_DH - 1);
            ST_WREC: lim_m1 = CNT_W'(T_WR - 1);
            default: lim_m1 = '0;
        endcase
    end

    assign phase_end = (cnt == lim_m1);
    assign sample    = (st_q == ST_RD) && (cnt == CNT_W'(T_AA - 1));

    // Next-phase selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: if (fire) begin
                if (used_q && (req_wr != last_wr_q)) st_d = ST_TURN;
                else                                 st_d = req_wr ? ST_WSET : ST_RD;
            end
            ST_TURN: st_d = op_wr_q ? ST_WSET : ST_RD;
            ST_RD:   if (phase_end) st_d = ST_IDLE;
            ST_WSET: if (phase_end) st_d = ST_WPUL;
            ST_WPUL: if (phase_end) st_d = ST_WHLD;
            ST_WHLD: if (phase_end) st_d = ST_WREC;
            ST_WREC: if (phase_end) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase register and direction history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            op_wr_q   <= 1'b0;
            last_wr_q <= 1'b0;
            used_q    <= 1'b0;
        end else begin
            st_q <= st_d;
            if (fire) begin
                op_wr_q   <= req_wr;
                last_wr_q <= req_wr;
                used_q    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sram_rd_capture.sv
// Read capture: registers each byte lane of the returned bus on the
// sample strobe, zeroing lanes that were not enabled, and pulses valid
// for one clock. Assumes lane_en is stable on the sample edge.
module sram_rd_capture #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Capture one byte lane or clear it when not selected.
        always_ff @(posedge clk) begin
            if (!rst_n)      lane_q <= '0;
            else if (sample) lane_q <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

    // One-clock valid after each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) rvalid <= 1'b0;
        else        rvalid <= sample;
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Top: byte-lane controller for an asynchronous static RAM. Accepts one
// request at a time, holds address and data for the whole access, and
// drives registered strobes decoded from the next sequencer phase.
// Assumes all T_* counts are at least 1 and T_AA <= T_RC.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LANES     = 2,
    parameter int LANE_W    = 8,
    parameter int T_RC      = 3,
    parameter int T_AA      = 3,
    parameter int T_AS      = 1,
    parameter int T_WP      = 2,
    parameter int T_DW      = 1,
    parameter int T_WHZ     = 1,
    parameter int T_DH      = 1,
    parameter int T_WR      = 1,
    parameter bit OE_LOW_WR = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_wr,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LANES*LANE_W-1:0]    req_wdata,
    input  logic [LANES-1:0]           req_mask,
    output logic                       rsp_valid,
    output logic [LANES*LANE_W-1:0]    rsp_rdata,
    output logic                       sram_cs_n,
    output logic                       sram_oe_n,
    output logic                       sram_we_n,
    output logic [LANES-1:0]           sram_be_n,
    output logic [ADDR_W-1:0]          sram_addr,
    output logic [LANES*LANE_W-1:0]    sram_dq_out,
    input  logic [LANES*LANE_W-1:0]    sram_dq_in,
    output logic                       sram_dq_oe
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int PW     = OE_LOW_WR ? int'(max_u(T_WP, T_WHZ + T_DW))
                                      : int'(max_u(T_WP, T_DW));
    localparam int MAXC   = int'(max_u(max_u(max_u(T_RC, T_AS), max_u(PW, T_DH)), T_WR));
    localparam int CNT_W  = $clog2(MAXC + 1) + 1;

    seq_state_t        st_q;
    seq_state_t        st_d;
    logic [CNT_W-1:0]  cnt;
    logic              sample;
    logic              fire;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  mask_d;
    strobe_t           str_d;
    strobe_t           str_q;
    logic [LANES-1:0]  be_q;

    assign req_ready = (st_q == ST_IDLE);
    assign fire      = req_valid && req_ready;
    assign mask_d    = fire ? req_mask : mask_q;
    assign str_d     = strobes_of(st_d, OE_LOW_WR);

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st_d != st_q),
        .cnt     (cnt)
    );

    sram_seq_fsm #(
        .CNT_W (CNT_W),
        .T_RC  (T_RC),
        .T_AA  (T_AA),
        .T_AS  (T_AS),
        .PW    (PW),
        .T_DH  (T_DH),
        .T_WR  (T_WR)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .req_wr (req_wr),
        .cnt    (cnt),
        .st_q   (st_q),
        .st_d   (st_d),
        .sample (sample)
    );

    sram_rd_capture #(.LANES(LANES), .LANE_W(LANE_W)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .lane_en (~sram_be_n),
        .dq_in   (sram_dq_in),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (fire) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // Register the strobes of the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_q <= STROBE_QUIET;
            be_q  <= '1;
        end else begin
            str_q <= str_d;
            be_q  <= str_d.cs_n ? '1 : ~mask_d;
        end
    end

    assign sram_cs_n   = str_q.cs_n;
    assign sram_oe_n   = str_q.oe_n;
    assign sram_we_n   = str_q.we_n;
    assign sram_dq_oe  = str_q.dq_oe;
    assign sram_be_n   = be_q;
    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
// Checker: port-level timing rules of the lane controller, bound to
// every instance of the top. Assumes the same parameters as the top.
module sram_lane_ctrl_chk #(
    parameter int ADDR_W    = 16,
    parameter int LANES     = 2,
    parameter int T_WP      = 2,
    parameter int T_DW      = 1,
    parameter int T_WHZ     = 1,
    parameter bit OE_LOW_WR = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              sram_cs_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [LANES-1:0]  sram_be_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_dq_oe
);

    localparam int PW_C = OE_LOW_WR ? ((T_WP > T_WHZ + T_DW) ? T_WP : T_WHZ + T_DW)
                                    : ((T_WP > T_DW) ? T_WP : T_DW);

    logic [7:0] we_lo_cnt;

    // Length of the current write-enable low run.
    always_ff @(posedge clk) begin
        if (!rst_n)          we_lo_cnt <= '0;
        else if (!sram_we_n) we_lo_cnt <= we_lo_cnt + 8'd1;
        else                 we_lo_cnt <= '0;
    end

    a_r2_we_high_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && !sram_oe_n && !OE_LOW_WR) |-> sram_we_n);

    a_r4_rsp_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    a_r6_select_before_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_cs_n));

    a_r6_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_lo_cnt == 8'(PW_C)));

    a_r7_drive_during_we: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_dq_oe);

    a_r7_drive_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !(!sram_cs_n && !sram_oe_n && sram_we_n));

    a_r8_lanes_need_select: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (sram_be_n == '1));

    a_r9_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_n |-> !req_ready);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .T_WP      (T_WP),
    .T_DW      (T_DW),
    .T_WHZ     (T_WHZ),
    .OE_LOW_WR (OE_LOW_WR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_cs_n  (sram_cs_n),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_be_n  (sram_be_n),
    .sram_addr  (sram_addr),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
// Bench: scoreboard test of the lane controller against a small behavioural
// memory keyed by the low address byte.
module sram_lane_ctrl_tb_top;

    localparam int T_RC = 3, T_AA = 3, T_AS = 1, T_WP = 2, T_DW = 1;
    localparam int T_WHZ = 1, T_DH = 1, T_WR = 1;
    localparam int PW_EXP  = (T_WP > T_DW) ? T_WP : T_DW;
    localparam int RD_BUSY = T_RC;
    localparam int WR_BUSY = T_AS + PW_EXP + T_DH + T_WR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_addr, sram_dq_out;
    logic [15:0] sram_dq_in;

    always #2 clk = ~clk;

    sram_lane_ctrl #(
        .T_RC(T_RC), .T_AA(T_AA), .T_AS(T_AS), .T_WP(T_WP), .T_DW(T_DW),
        .T_WHZ(T_WHZ), .T_DH(T_DH), .T_WR(T_WR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_cs_n(sram_cs_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_be_n(sram_be_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int contend_bad = 0;
    int addr_bad = 0;
    int undriven_bad = 0;
    bit done = 1'b0;

    logic [15:0] mem    [256];
    logic [15:0] shadow [256];
    logic [15:0] exp_q  [$];
    logic [1:0]  cur_mask = '0;
    bit          have_prev = 1'b0;
    bit          last_wr = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory read path: drives the bus only when selected for reading.
    always_comb begin
        if (!sram_cs_n && !sram_oe_n && sram_we_n) begin
            for (int l = 0; l < 2; l++)
                sram_dq_in[l*8 +: 8] = !sram_be_n[l] ? mem[sram_addr[7:0]][l*8 +: 8] : 8'h00;
        end else begin
            sram_dq_in = 16'h0000;
        end
    end

    // Memory write path: stores enabled lanes while write enable is low.
    always @(posedge clk) begin
        if (rst_n && !sram_we_n && !sram_cs_n) begin
            if (!sram_dq_oe) undriven_bad++;
            for (int l = 0; l < 2; l++)
                if (!sram_be_n[l]) mem[sram_addr[7:0]][l*8 +: 8] <= sram_dq_out[l*8 +: 8];
        end
    end

    // Port monitors for strobe shapes, contention and address stability.
    logic        prev_we = 1'b1, prev_oe = 1'b1, prev_cs = 1'b1, prev_rv = 1'b0;
    logic [15:0] prev_addr = '0;
    int          we_len = 0, oe_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_dq_oe && !sram_cs_n && !sram_oe_n && sram_we_n) contend_bad++;
            if (!sram_cs_n && !prev_cs && sram_addr != prev_addr) addr_bad++;
            if (!sram_we_n && prev_we) begin
                check(sram_be_n == ~cur_mask, "R8", "write lane enables", 32'(sram_be_n), 32'(~cur_mask));
                check(!sram_cs_n && !sram_dq_oe == 1'b0, "R7", "select and drive at we fall",
                      {30'd0, sram_cs_n, sram_dq_oe}, 32'd1);
            end
            if (!sram_we_n) begin
                we_len++;
                if (!sram_oe_n) check(1'b0, "R6", "oe low during write pulse", 32'd0, 32'd1);
            end else if (!prev_we) begin
                check(we_len == PW_EXP, "R6", "write pulse cycles", 32'(we_len), 32'(PW_EXP));
                check(sram_dq_oe == 1'b1, "R7", "data held after we rise", 32'(sram_dq_oe), 32'd1);
                we_len = 0;
            end
            if (!sram_oe_n && prev_oe) begin
                check(sram_we_n == 1'b1, "R2", "we during read", 32'(sram_we_n), 32'd1);
                check(sram_be_n == ~cur_mask, "R8", "read lane enables", 32'(sram_be_n), 32'(~cur_mask));
            end
            if (!sram_oe_n) oe_len++;
            else if (!prev_oe) begin
                check(oe_len == T_RC, "R2", "read strobe cycles", 32'(oe_len), 32'(T_RC));
                oe_len = 0;
            end
            if (rsp_valid) begin
                check(!prev_rv, "R4", "valid longer than one clock", 32'(prev_rv), 32'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected read response", 32'(rsp_rdata), 32'd0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rsp_rdata == e, "R3", "read data", 32'(rsp_rdata), 32'(e));
                end
            end
        end
        prev_we = sram_we_n; prev_oe = sram_oe_n; prev_cs = sram_cs_n;
        prev_rv = rsp_valid; prev_addr = sram_addr;
    end

    // Driver: issue one request at a negedge, push expectations, time busy.
    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        int  busy, exp_busy;
        bit  turn;
        logic [15:0] e;
        while (!req_ready) @(negedge clk);
        turn     = have_prev && (wr != last_wr);
        exp_busy = (wr ? WR_BUSY : RD_BUSY) + (turn ? 1 : 0);
        have_prev = 1'b1;
        last_wr   = wr;
        cur_mask  = m;
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        if (wr) begin
            for (int l = 0; l < 2; l++)
                if (m[l]) shadow[a[7:0]][l*8 +: 8] = d[l*8 +: 8];
        end else begin
            for (int l = 0; l < 2; l++)
                e[l*8 +: 8] = m[l] ? shadow[a[7:0]][l*8 +: 8] : 8'h00;
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        if (turn) check(busy == exp_busy, "R10", "busy with turnaround", 32'(busy), 32'(exp_busy));
        else      check(busy == exp_busy, "R9", "busy cycles", 32'(busy), 32'(exp_busy));
    endtask

    task automatic check_idle(input string tag);
        check(req_ready == 1'b1, tag, "ready", 32'(req_ready), 32'd1);
        check({sram_cs_n, sram_oe_n, sram_we_n} == 3'b111, tag, "strobes",
              32'({sram_cs_n, sram_oe_n, sram_we_n}), 32'h7);
        check(sram_be_n == 2'b11 && !sram_dq_oe && !rsp_valid, tag, "lanes/drive/valid",
              {28'd0, sram_be_n, sram_dq_oe, rsp_valid}, 32'hC);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'h0000;
            shadow[i] = 16'h0000;
        end
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        issue(1'b1, 16'h0010, 16'hA5C3, 2'b11);
        issue(1'b0, 16'h0010, 16'h0000, 2'b11);
        issue(1'b1, 16'h0010, 16'h7700, 2'b10);
        issue(1'b0, 16'h0010, 16'h0000, 2'b11);
        issue(1'b1, 16'h0011, 16'h0012, 2'b01);
        issue(1'b0, 16'h0011, 16'h0000, 2'b01);
        issue(1'b0, 16'h0011, 16'h0000, 2'b10);
        issue(1'b1, 16'h0010, 16'hFFFF, 2'b00);   // R8 empty mask writes nothing
        issue(1'b0, 16'h0010, 16'h0000, 2'b11);
        issue(1'b0, 16'hFFFF, 16'h0000, 2'b11);
        issue(1'b1, 16'hFFFF, 16'hBEEF, 2'b11);
        issue(1'b1, 16'h0000, 16'h1234, 2'b11);
        issue(1'b0, 16'hFFFF, 16'h0000, 2'b11);
        issue(1'b0, 16'h0000, 16'h0000, 2'b11);
        issue(1'b0, 16'h8042, 16'h0000, 2'b11);

        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R3", "reads left unanswered", 32'(exp_q.size()), 32'd0);
        check(contend_bad == 0, "R7", "bus contention cycles", 32'(contend_bad), 32'd0);
        check(undriven_bad == 0, "R7", "undriven write cycles", 32'(undriven_bad), 32'd0);
        check(addr_bad == 0, "R5", "address changes under select", 32'(addr_bad), 32'd0);
        check(mem[8'h10] == 16'h77C3, "R8", "stored word after lane writes",
              32'(mem[8'h10]), 32'h77C3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule